// File: doc/BRIEF.md
# Clock Group Stop Controller

This block sits between a clock synthesizer's output dividers and its output pins. It takes eight already-generated group clocks and passes each to its pin through a gate. Three active-low asynchronous controls decide which gates are open. One control parks the processor-bus clocks. One parks the I/O-bus clocks, except for one free-running I/O-bus copy. The third, power-down, drives every output low and then switches off the oscillator and the VCOs. Each control is brought into the clock domain it gates through its own two-flop synchronizer. Each gate changes its enable only while its clock is low, so a clock always stops in the low state and always restarts with a full high phase.

A power sequencer runs on the reference clock. It has five states: `ST_OSC` (oscillator on, waiting `OSC_WAIT` cycles), `ST_VCO` (VCOs on, waiting `LOCK_WAIT` cycles), `ST_RUN` (gates released), `ST_DRAIN` (gates closed, waiting `DRAIN_WAIT` cycles) and `ST_OFF` (oscillator and VCOs off). Its transitions are: reset enters `ST_OSC`; `ST_OSC`→`ST_VCO` and `ST_VCO`→`ST_RUN` when their counts expire; `ST_OSC`/`ST_VCO`→`ST_OFF` on a power-down request (abort); `ST_RUN`→`ST_DRAIN` on a power-down request; `ST_DRAIN`→`ST_OFF` when the drain count expires; `ST_OFF`→`ST_OSC` when power-down is released. The two stop controls are ignored outside `ST_RUN`. `OSC_WAIT` plus `LOCK_WAIT` set the power-up latency and are sized to keep it below 3 ms.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, `osc_en` is 1, `vco_en` is 0 and every `grp_out` bit is 0. After release, `vco_en` rises on the `OSC_WAIT`-th rising edge of the reference clock (group index 6), and after `LOCK_WAIT` more edges all eight groups run.
- R2: While `cpu_stop_n` is low, the processor clock (index 0) and the fixed 66 MHz group (index 1) stay low. Indices 2, 3, 4, 5, 6 and 7 keep running.
- R3: While `pci_stop_n` is low, the gated I/O-bus clock (index 4) stays low. The free-running I/O-bus clock (index 5) and all other groups keep running.
- R4: Every high pulse on a `grp_out` bit lasts exactly one full high phase of its group clock. A stopped output rests at 0.
- R5: A stop control that changes between two rising edges of a group clock takes effect at the third rising edge of that clock that follows the change. On assertion that edge makes no high pulse; on release it makes the first full pulse.
- R6: When `pd_n` falls, all outputs go low, including the reference (index 6) and 48 MHz (index 7) groups. `osc_en` and `vco_en` then fall together on the (3 + `DRAIN_WAIT`)-th reference edge after the fall.
- R7: `cpu_stop_n` and `pci_stop_n` have no effect during power-down. Toggling them neither moves the shutdown edge nor produces any output edge.
- R8: When `pd_n` rises in the off state, `osc_en` rises on the third reference edge, `vco_en` rises `OSC_WAIT` edges later, and the outputs resume after a further `LOCK_WAIT` edges.
- R9: A `pd_n` fall during warm-up (oscillator or VCO wait) turns `osc_en` and `vco_en` off on the third reference edge, without a drain phase and with no output edges.
- R10: `vco_en` is never 1 while `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| grp_clk | input | 8 | Group clocks: 0 processor, 1 fixed 66 MHz, 2 half-rate, 3 interrupt controller, 4 I/O bus, 5 free-running I/O bus, 6 reference, 7 48 MHz |
| cpu_stop_n | input | 1 | Asynchronous active-low stop for groups 0 and 1 |
| pci_stop_n | input | 1 | Asynchronous active-low stop for group 4 |
| pd_n | input | 1 | Asynchronous active-low power-down |
| grp_out | output | 8 | Gated group clocks, same index order as `grp_clk` |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The sequencer outputs move on fixed reference edges after a control change. Two edges pass through the synchronizer, so `osc_en` reacts on the third edge after `pd_n` changes. The wait states add exactly `OSC_WAIT` or `DRAIN_WAIT` edges. The bench counts these edges and samples at the falling edge just before and just after the expected one. A gate reacts on the third rising edge of its own clock. The bench sets a stop control just after an edge and reads the output 1 ns after the second and third following edges. Run and stop checks count output edges over windows that start only after the slowest group has had three edges to settle.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
    localparam int NGRP  = 8;
    localparam int G_CPU  = 0;
    localparam int G_B66  = 1;
    localparam int G_HALF = 2;
    localparam int G_APIC = 3;
    localparam int G_PCI  = 4;
    localparam int G_PCIF = 5;
    localparam int G_REF  = 6;
    localparam int G_USB  = 7;

    typedef enum logic [1:0] {SRC_NONE, SRC_CPU, SRC_PCI} stop_src_e;

    typedef enum logic [2:0] {ST_OSC, ST_VCO, ST_RUN, ST_DRAIN, ST_OFF} pwr_state_e;

    function automatic stop_src_e src_of(int g);
        if (g == G_CPU || g == G_B66) return SRC_CPU;
        if (g == G_PCI)               return SRC_PCI;
        return SRC_NONE;
    endfunction
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic stop_n,
    output logic gclk
);
    logic run_s;
    logic stop_s;
    logic en;

    clkstop_sync #(.RST_VAL(1'b0)) u_run (
        .clk(clk), .rst_n(rst_n), .d(run_req), .q(run_s)
    );

    clkstop_sync #(.RST_VAL(1'b1)) u_stop (
        .clk(clk), .rst_n(rst_n), .d(stop_n), .q(stop_s)
    );

    // enable moves only on the falling edge, i.e. while the clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en <= 1'b0;
        else        en <= run_s & stop_s;
    end

    assign gclk = clk & en;
endmodule

// File: rtl/clkstop_pwr_fsm.sv
`timescale 1ns/1ps
module clkstop_pwr_fsm
    import clkstop_pkg::*;
#(
    parameter int OSC_WAIT   = 1024,
    parameter int LOCK_WAIT  = 2048,
    parameter int DRAIN_WAIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic run_req,
    output logic osc_en,
    output logic vco_en
);
    localparam int MAXW = (OSC_WAIT > LOCK_WAIT) ?
                          ((OSC_WAIT > DRAIN_WAIT) ? OSC_WAIT : DRAIN_WAIT) :
                          ((LOCK_WAIT > DRAIN_WAIT) ? LOCK_WAIT : DRAIN_WAIT);
    localparam int CW = $clog2(MAXW + 1);
    localparam logic [CW-1:0] OSC_LAST   = CW'(OSC_WAIT - 1);
    localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_WAIT - 1);
    localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_WAIT - 1);

    pwr_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic pd_s;

    clkstop_sync #(.RST_VAL(1'b1)) u_pd (
        .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_s)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OSC:   if (!pd_s) nxt = ST_OFF;
                      else if (cnt == OSC_LAST) nxt = ST_VCO;
            ST_VCO:   if (!pd_s) nxt = ST_OFF;
                      else if (cnt == LOCK_LAST) nxt = ST_RUN;
            ST_RUN:   if (!pd_s) nxt = ST_DRAIN;
            ST_DRAIN: if (cnt == DRAIN_LAST) nxt = ST_OFF;
            ST_OFF:   if (pd_s) nxt = ST_OSC;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OSC;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= '0;
            else if (state == ST_OSC || state == ST_VCO || state == ST_DRAIN)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_OSC:   {osc_en, vco_en, run_req} = 3'b100;
            ST_VCO:   {osc_en, vco_en, run_req} = 3'b110;
            ST_RUN:   {osc_en, vco_en, run_req} = 3'b111;
            ST_DRAIN: {osc_en, vco_en, run_req} = 3'b110;
            ST_OFF:   {osc_en, vco_en, run_req} = 3'b000;
            default:  {osc_en, vco_en, run_req} = 3'b000;
        endcase
    end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int OSC_WAIT   = 1024,
    parameter int LOCK_WAIT  = 2048,
    parameter int DRAIN_WAIT = 64
) (
    input  logic            rst_n,
    input  logic [NGRP-1:0] grp_clk,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pd_n,
    output logic [NGRP-1:0] grp_out,
    output logic            osc_en,
    output logic            vco_en
);
    logic run_req;

    clkstop_pwr_fsm #(
        .OSC_WAIT(OSC_WAIT), .LOCK_WAIT(LOCK_WAIT), .DRAIN_WAIT(DRAIN_WAIT)
    ) u_pwr (
        .clk(grp_clk[G_REF]), .rst_n(rst_n), .pd_n(pd_n),
        .run_req(run_req), .osc_en(osc_en), .vco_en(vco_en)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam stop_src_e SRC = src_of(g);
        logic stop_sel;
        if (SRC == SRC_CPU) begin : g_cpu
            assign stop_sel = cpu_stop_n;
        end else if (SRC == SRC_PCI) begin : g_pci
            assign stop_sel = pci_stop_n;
        end else begin : g_free
            assign stop_sel = 1'b1;
        end

        clkstop_gate u_gate (
            .clk(grp_clk[g]), .rst_n(rst_n), .run_req(run_req),
            .stop_n(stop_sel), .gclk(grp_out[g])
        );
    end
endmodule

module clkstop_ctrl_chk
    import clkstop_pkg::*;
(
    input logic            rst_n,
    input logic            ref_clk,
    input logic [NGRP-1:0] grp_out,
    input logic            osc_en,
    input logic            vco_en
);
    // R10: VCOs never run without the oscillator
    a_r10_vco_needs_osc: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !osc_en |-> !vco_en);

    // R8: the oscillator is already on when the VCOs start
    a_r8_osc_before_vco: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(vco_en) |-> $past(osc_en));

    // R6: outputs are quiet before the oscillator goes off
    a_r6_quiet_before_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(grp_out == '0));

    // R6: outputs stay low throughout the off state
    a_r6_quiet_when_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !osc_en |-> (grp_out == '0));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
    .rst_n(rst_n), .ref_clk(grp_clk[G_REF]), .grp_out(grp_out),
    .osc_en(osc_en), .vco_en(vco_en)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
    import clkstop_pkg::*;

    localparam int OSC_W = 8, LOCK_W = 16, DRAIN_W = 32;
    localparam int K_OSC = 0, K_VCO = 1, K_LVL = 2, K_RUN = 3, K_ALL0 = 4, K_RUNTS = 5;

    logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1;
    logic c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0, c5 = 0, c6 = 0, c7 = 0;
    logic [NGRP-1:0] gclk;
    logic [NGRP-1:0] gout;
    logic osc_en, vco_en;

    always #3  c0 = ~c0;
    always #6  c1 = ~c1;
    always #6  c2 = ~c2;
    always #24 c3 = ~c3;
    always #15 c4 = ~c4;
    always #15 c5 = ~c5;
    always #4  c6 = ~c6;   // reference, 125 MHz
    always #5  c7 = ~c7;
    assign gclk = {c7, c6, c5, c4, c3, c2, c1, c0};

    clkstop_ctrl #(.OSC_WAIT(OSC_W), .LOCK_WAIT(LOCK_W), .DRAIN_WAIT(DRAIN_W)) u0 (
        .rst_n(rst_n), .grp_clk(gclk), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .pd_n(pd_n), .grp_out(gout), .osc_en(osc_en), .vco_en(vco_en)
    );

    function automatic real half_ns(int g);
        case (g)
            0: return 3.0;   1: return 6.0;   2: return 6.0;  3: return 24.0;
            4: return 15.0;  5: return 15.0;  6: return 4.0;  default: return 5.0;
        endcase
    endfunction

    // edge and pulse-width monitor
    int edge_cnt[NGRP] = '{default: 0};
    real t_rise[NGRP] = '{default: 0.0};
    int runts = 0;
    logic [NGRP-1:0] prev = '0;
    always @(gout) begin
        for (int g = 0; g < NGRP; g++) begin
            if (gout[g] && !prev[g]) begin
                edge_cnt[g]++;
                t_rise[g] = $realtime;
            end else if (!gout[g] && prev[g]) begin
                if (($realtime - t_rise[g]) > half_ns(g) + 0.01 ||
                    ($realtime - t_rise[g]) < half_ns(g) - 0.01)
                    runts++;
            end
        end
        prev = gout;
    end

    // scoreboard
    typedef struct {string req; int kind; int g; int base; int exp;} item_t;
    item_t sb[$];
    event sb_ev;
    int n_run = 0, n_fail = 0;
    int snap[NGRP];
    bit done = 0;

    function automatic int observe(item_t it);
        case (it.kind)
            K_OSC:   return int'(osc_en);
            K_VCO:   return int'(vco_en);
            K_LVL:   return int'(gout[it.g]);
            K_RUN:   return (edge_cnt[it.g] - it.base) > 0 ? 1 : 0;
            K_ALL0:  return (gout == '0) ? 1 : 0;
            default: return runts;
        endcase
    endfunction

    initial begin : monitor
        forever begin
            @(sb_ev);
            while (sb.size() != 0) begin
                item_t it;
                int act;
                it = sb.pop_front();
                act = observe(it);
                n_run++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d grp=%0d actual=%0d expected=%0d at %0t",
                             it.req, it.kind, it.g, act, it.exp, $time);
                end
            end
        end
    end

    task automatic push(string req, int kind, int g, int base, int exp);
        item_t it;
        it.req = req; it.kind = kind; it.g = g; it.base = base; it.exp = exp;
        sb.push_back(it);
        ->sb_ev;
    endtask

    task automatic snap_all();
        for (int g = 0; g < NGRP; g++) snap[g] = edge_cnt[g];
    endtask

    task automatic push_run(string req, logic [NGRP-1:0] mask);
        for (int g = 0; g < NGRP; g++) push(req, K_RUN, g, snap[g], int'(mask[g]));
    endtask

    task automatic ref_edges(int n);
        repeat (n) @(posedge c6);
        @(negedge c6);
    endtask

    task automatic en_check(string req, int o, int v);
        push(req, K_OSC, 0, 0, o);
        push(req, K_VCO, 0, 0, v);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset state
        ref_edges(3);
        en_check("R1", 1, 0);
        push("R1", K_ALL0, 0, 0, 1);
        rst_n = 1'b1;                        // released at a reference falling edge
        ref_edges(OSC_W - 1);
        en_check("R1", 1, 0);
        ref_edges(1);
        en_check("R1", 1, 1);
        #600;
        snap_all(); #400; push_run("R1", 8'hFF);

        // R5: exact stop latency on the processor group
        @(posedge c0); #1 cpu_stop_n = 1'b0;
        @(posedge c0);
        @(posedge c0); #1 push("R5", K_LVL, G_CPU, 0, 1);
        @(posedge c0); #1 push("R5", K_LVL, G_CPU, 0, 0);
        // R2: processor and 66 MHz groups parked, others run
        #300;
        snap_all(); #400; push_run("R2", 8'hFC);
        push("R4", K_LVL, G_CPU, 0, 0);
        push("R4", K_LVL, G_B66, 0, 0);
        // R5: exact restart latency
        @(posedge c0); #1 cpu_stop_n = 1'b1;
        @(posedge c0);
        @(posedge c0); #1 push("R5", K_LVL, G_CPU, 0, 0);
        @(posedge c0); #1 push("R5", K_LVL, G_CPU, 0, 1);
        #300;

        // R3: I/O-bus stop spares the free-running copy
        pci_stop_n = 1'b0;
        #300;
        snap_all(); #400; push_run("R3", 8'hEF);
        push("R4", K_LVL, G_PCI, 0, 0);
        pci_stop_n = 1'b1;
        #300;
        snap_all(); #400; push_run("R3", 8'hFF);

        // R6 / R7: power-down with stop controls toggling during drain
        @(negedge c6);
        pd_n = 1'b0;
        ref_edges(10); cpu_stop_n = 1'b0;
        ref_edges(10); pci_stop_n = 1'b0;
        ref_edges(10); cpu_stop_n = 1'b1;
        snap_all();
        ref_edges(DRAIN_W + 2 - 30);
        push_run("R6", 8'h00);
        en_check("R7", 1, 1);
        ref_edges(1);
        en_check("R6", 0, 0);
        pci_stop_n = 1'b1;
        cpu_stop_n = 1'b0;
        snap_all(); #400; push_run("R7", 8'h00);
        en_check("R7", 0, 0);
        cpu_stop_n = 1'b1;

        // R8: wake-up ordering
        @(negedge c6);
        pd_n = 1'b1;
        ref_edges(2); en_check("R8", 0, 0);
        ref_edges(1); en_check("R8", 1, 0);
        ref_edges(OSC_W - 1); en_check("R8", 1, 0);
        ref_edges(1); en_check("R8", 1, 1);
        #800;
        snap_all(); #400; push_run("R8", 8'hFF);

        // R9: abort during VCO warm-up
        @(negedge c6);
        pd_n = 1'b0;
        ref_edges(DRAIN_W + 8);
        en_check("R9", 0, 0);
        pd_n = 1'b1;
        ref_edges(3 + OSC_W + 1);            // in VCO wait
        pd_n = 1'b0;
        ref_edges(2); en_check("R9", 1, 1);
        ref_edges(1); en_check("R9", 0, 0);
        snap_all(); #400; push_run("R9", 8'h00);

        pd_n = 1'b1;
        #1000;
        snap_all(); #400; push_run("R8", 8'hFF);

        // R4: no runt pulse anywhere over the whole run
        push("R4", K_RUNTS, 0, 0, 0);

        #20;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule